// File: doc/BRIEF.md
# Extended Control Register Read Unit

This block executes the single instruction that copies an extended control register into the data-high and accumulator registers. An issue strobe presents a decoded instruction (its three opcode bytes and four prefix flags), the 64-bit count register, the processor feature word, the low word of control register 4, the current data-high and accumulator values, the arithmetic flags and a 64-bit-mode flag. One clock later the block reports either a result or a fault. The result is a new accumulator and data-high value, plus the flags passed through unchanged. A fault is reported as a valid strobe with a vector number and an error code.

The block holds one 64-bit extended control register at index 0. No other index exists. A preload port lets the environment set that register's value. The lower half of the register goes to the accumulator and the upper half goes to data-high. In 64-bit mode the upper halves of both destinations are cleared. Outside 64-bit mode, the upper halves keep the values they had before the instruction. When a fault is raised, no result is produced.

Top module: `xcr_read_unit`

## Requirements
- R1: Only the opcode bytes `op_bytes[23:16]=0x0F`, `op_bytes[15:8]=0x01`, `op_bytes[7:0]=0xD0` are executed. An issue with any other opcode produces neither `res_valid` nor `fault_valid`.
- R2: The register index is `count_val[31:0]`. Bits 63:32 of `count_val` have no effect on the outcome or on the data.
- R3: On success, `res_valid` is high for exactly the one cycle after the issue edge. In that cycle, `res_ax[31:0]` equals register bits 31:0 and `res_dx[31:0]` equals register bits 63:32.
- R4: When `mode64` is 1, `res_ax[63:32]` and `res_dx[63:32]` are 0. When `mode64` is 0, they equal `old_ax[63:32]` and `old_dx[63:32]`.
- R5: If no invalid-opcode condition holds and the index is nonzero, the block raises a general-protection fault: `fault_valid`=1, `fault_vec`=13 and `fault_err`=0.
- R6: An invalid-opcode fault (`fault_valid`=1, `fault_vec`=6) is raised when `feat_word[26]` is 0 or when `cr4_val[18]` is 0.
- R7: An invalid-opcode fault (`fault_vec`=6) is raised when any of `pfx_lock`, `pfx_opsize`, `pfx_rep` or `pfx_repne` is 1.
- R8: Invalid-opcode conditions take priority over the index check. `res_valid` and `fault_valid` are never high together.
- R9: `flags_out` equals the `flags_in` value present at the issue.
- R10: After reset, register 0 holds 0x0000_0000_0000_0001. A preload write changes it only when `pre_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | Instruction presented this cycle |
| op_bytes | input | 24 | Opcode bytes, first byte in bits 23:16 |
| pfx_lock | input | 1 | LOCK prefix present |
| pfx_opsize | input | 1 | 0x66 prefix present |
| pfx_rep | input | 1 | 0xF3 prefix present |
| pfx_repne | input | 1 | 0xF2 prefix present |
| count_val | input | 64 | Count register value |
| feat_word | input | 32 | Processor feature word |
| cr4_val | input | 32 | Control register 4, low word |
| mode64 | input | 1 | 64-bit operation |
| old_ax | input | 64 | Accumulator value before the instruction |
| old_dx | input | 64 | Data-high value before the instruction |
| flags_in | input | 6 | Arithmetic flags before the instruction |
| pre_we | input | 1 | Preload write strobe |
| pre_idx | input | 32 | Preload register index |
| pre_data | input | 64 | Preload data |
| res_valid | output | 1 | Result strobe |
| res_ax | output | 64 | New accumulator value |
| res_dx | output | 64 | New data-high value |
| fault_valid | output | 1 | Fault strobe |
| fault_vec | output | 8 | Fault vector (6 invalid opcode, 13 general protection) |
| fault_err | output | 16 | Fault error code |
| flags_out | output | 6 | Flags after the instruction |

## Verification
Every outcome (result, fault, vector and flags) is registered once. Each is therefore due in the cycle after the rising edge that samples `issue`, and only in that cycle. The bench drives its inputs on the falling edge and samples on the next falling edge, which lands in the middle of the result cycle. It then drops `issue` and samples one more falling edge to confirm that both strobes have returned low. Preload writes are made with no instruction pending, and the following read is issued only after the write edge has passed.

// File: rtl/xcr_read_unit.sv
module xcr_read_unit #(
  parameter int XLEN     = 64,
  parameter int FLAG_W   = 6,
  parameter int FEAT_BIT = 26,
  parameter int OSE_BIT  = 18,
  parameter logic [23:0] OPC = 24'h0F01D0,
  parameter logic [7:0]  VEC_UD = 8'd6,
  parameter logic [7:0]  VEC_GP = 8'd13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [23:0]       op_bytes,
  input  logic              pfx_lock,
  input  logic              pfx_opsize,
  input  logic              pfx_rep,
  input  logic              pfx_repne,
  input  logic [XLEN-1:0]   count_val,
  input  logic [31:0]       feat_word,
  input  logic [31:0]       cr4_val,
  input  logic              mode64,
  input  logic [XLEN-1:0]   old_ax,
  input  logic [XLEN-1:0]   old_dx,
  input  logic [FLAG_W-1:0] flags_in,
  input  logic              pre_we,
  input  logic [31:0]       pre_idx,
  input  logic [XLEN-1:0]   pre_data,
  output logic              res_valid,
  output logic [XLEN-1:0]   res_ax,
  output logic [XLEN-1:0]   res_dx,
  output logic              fault_valid,
  output logic [7:0]        fault_vec,
  output logic [15:0]       fault_err,
  output logic [FLAG_W-1:0] flags_out
);
  localparam int HALF = XLEN / 2;
  localparam logic [XLEN-1:0] XCR0_RST = {{(XLEN-1){1'b0}}, 1'b1};

  logic [XLEN-1:0] xcr0;
  logic            go, ud, gp;
  logic [HALF-1:0] sel, up_ax, up_dx;

  assign go    = issue && (op_bytes == OPC);
  assign sel   = count_val[HALF-1:0];
  assign ud    = pfx_lock | pfx_opsize | pfx_rep | pfx_repne
               | ~feat_word[FEAT_BIT] | ~cr4_val[OSE_BIT];
  assign gp    = !ud && (sel != '0);
  assign up_ax = mode64 ? '0 : old_ax[XLEN-1:HALF];
  assign up_dx = mode64 ? '0 : old_dx[XLEN-1:HALF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xcr0 <= XCR0_RST;
    else if (pre_we && pre_idx == '0) xcr0 <= pre_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      fault_valid <= 1'b0;
      fault_vec   <= '0;
      fault_err   <= '0;
      res_ax      <= '0;
      res_dx      <= '0;
      flags_out   <= '0;
    end else begin
      res_valid   <= go && !ud && !gp;
      fault_valid <= go && (ud || gp);
      if (go) begin
        fault_vec <= ud ? VEC_UD : VEC_GP;
        fault_err <= '0;
        flags_out <= flags_in;
        if (!ud && !gp) begin
          res_ax <= {up_ax, xcr0[HALF-1:0]};
          res_dx <= {up_dx, xcr0[XLEN-1:HALF]};
        end
      end
    end
  end
endmodule

// File: rtl/xcr_read_unit_chk.sv
module xcr_read_unit_chk #(
  parameter int XLEN   = 64,
  parameter int FLAG_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue,
  input logic [23:0]       op_bytes,
  input logic              pfx_lock,
  input logic              pfx_opsize,
  input logic              pfx_rep,
  input logic              pfx_repne,
  input logic [XLEN-1:0]   count_val,
  input logic [31:0]       feat_word,
  input logic [31:0]       cr4_val,
  input logic              mode64,
  input logic [FLAG_W-1:0] flags_in,
  input logic              res_valid,
  input logic [XLEN-1:0]   res_ax,
  input logic [XLEN-1:0]   res_dx,
  input logic              fault_valid,
  input logic [7:0]        fault_vec,
  input logic [FLAG_W-1:0] flags_out
);
  localparam int HALF = XLEN / 2;
  logic hit;
  assign hit = issue && op_bytes == 24'h0F01D0;

  assert_foreign_op_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op_bytes != 24'h0F01D0) |=> (!res_valid && !fault_valid));

  assert_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || fault_valid) |-> $past(hit));

  assert_upper_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode64) |=> (!res_valid || (res_ax[XLEN-1:HALF] == '0 && res_dx[XLEN-1:HALF] == '0)));

  assert_gp_vec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !pfx_lock && !pfx_opsize && !pfx_rep && !pfx_repne && feat_word[26] && cr4_val[18]
     && count_val[HALF-1:0] != '0) |=> (fault_valid && fault_vec == 8'd13));

  assert_ud_feat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && (!feat_word[26] || !cr4_val[18])) |=> (fault_valid && fault_vec == 8'd6));

  assert_ud_pfx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && (pfx_lock || pfx_opsize || pfx_rep || pfx_repne)) |=> (fault_valid && fault_vec == 8'd6));

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && fault_valid));

  assert_flags_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (flags_out == $past(flags_in)));
endmodule

bind xcr_read_unit xcr_read_unit_chk #(.XLEN(XLEN), .FLAG_W(FLAG_W)) u_chk (.*);

// File: tb/test_xcr_read_unit.sv
module test_xcr_read_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [23:0] op_bytes = 24'h0F01D0;
  logic        pfx_lock = 0, pfx_opsize = 0, pfx_rep = 0, pfx_repne = 0;
  logic [63:0] count_val = '0;
  logic [31:0] feat_word = 32'h0400_0000;
  logic [31:0] cr4_val = 32'h0004_0000;
  logic        mode64 = 1'b0;
  logic [63:0] old_ax = '0, old_dx = '0;
  logic [5:0]  flags_in = '0;
  logic        pre_we = 1'b0;
  logic [31:0] pre_idx = '0;
  logic [63:0] pre_data = '0;
  logic        res_valid, fault_valid;
  logic [63:0] res_ax, res_dx;
  logic [7:0]  fault_vec;
  logic [15:0] fault_err;
  logic [5:0]  flags_out;

  int checks = 0;
  int errors = 0;
  logic [63:0] model_xcr0 = 64'h1;

  always #10 clk = ~clk;

  xcr_read_unit i_xcr_read_unit (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_one(input logic [3:0] pfx, input bit feat, input bit ose,
                         input logic [63:0] cnt, input bit m64, input logic [23:0] opc,
                         input bit idle_check);
    bit exp_ud, exp_gp, exp_ok, hit;
    logic [63:0] ea, ed;
    @(negedge clk);
    {pfx_lock, pfx_opsize, pfx_rep, pfx_repne} = pfx;
    feat_word = feat ? 32'hFFFF_FFFF : 32'hFBFF_FFFF;
    cr4_val   = ose  ? 32'h0004_0000 : 32'hFFFB_FFFF;
    count_val = cnt;
    mode64    = m64;
    op_bytes  = opc;
    old_ax    = {cnt[15:0], 16'hA5A5, 32'h1234_5678} ^ 64'h1111_0000_0000_0000;
    old_dx    = {16'h5A5A, cnt[31:16], 32'h9ABC_DEF0};
    flags_in  = cnt[5:0] ^ {pfx, feat, ose};
    issue     = 1'b1;
    hit    = (opc == 24'h0F01D0);
    exp_ud = (pfx != 0) || !feat || !ose;
    exp_gp = !exp_ud && (cnt[31:0] != 0);
    exp_ok = hit && !exp_ud && !exp_gp;
    ea = {m64 ? 32'h0 : old_ax[63:32], model_xcr0[31:0]};
    ed = {m64 ? 32'h0 : old_dx[63:32], model_xcr0[63:32]};
    @(negedge clk);
    issue = 1'b0;
    if (!hit) begin
      chk(!res_valid && !fault_valid, "R1 foreign opcode strobes", {res_valid, fault_valid}, 0);
    end else if (exp_ok) begin
      chk(res_valid && !fault_valid, "R3 result strobe", {res_valid, fault_valid}, 2);
      chk(res_ax[31:0] == ea[31:0] && res_dx[31:0] == ed[31:0], "R3 data halves",
          {res_dx[31:0], res_ax[31:0]}, {ed[31:0], ea[31:0]});
      chk(res_ax[63:32] == ea[63:32] && res_dx[63:32] == ed[63:32], "R4 upper halves",
          {res_dx[63:32], res_ax[63:32]}, {ed[63:32], ea[63:32]});
      chk(flags_out == flags_in, "R9 flags", flags_out, flags_in);
      if (cnt[63:32] != 0) chk(res_valid, "R2 upper count ignored", res_valid, 1);
    end else begin
      chk(fault_valid && !res_valid, exp_ud ? "R8 fault only, no result" : "R5 fault only",
          {res_valid, fault_valid}, 1);
      if (pfx != 0)
        chk(fault_vec == 8'd6, "R7 prefix vector", fault_vec, 6);
      else if (!feat || !ose)
        chk(fault_vec == 8'd6, "R6 feature/enable vector", fault_vec, 6);
      if (exp_ud && cnt[31:0] != 0)
        chk(fault_vec == 8'd6, "R8 priority over index", fault_vec, 6);
      if (exp_gp)
        chk(fault_vec == 8'd13 && fault_err == 0, "R5 general protection", {fault_err, fault_vec}, 13);
      chk(flags_out == flags_in, "R9 flags on fault", flags_out, flags_in);
    end
    if (idle_check) begin
      @(negedge clk);
      chk(!res_valid && !fault_valid, "R3 single cycle strobe", {res_valid, fault_valid}, 0);
    end
  endtask

  task automatic preload(input logic [31:0] idx, input logic [63:0] d);
    @(negedge clk);
    pre_we = 1'b1; pre_idx = idx; pre_data = d;
    @(negedge clk);
    pre_we = 1'b0;
    if (idx == 0) model_xcr0 = d;
  endtask

  function automatic logic [63:0] idx_pick(input int k);
    case (k)
      0: return 64'h0;
      1: return 64'h1;
      2: return 64'h0000_0000_8000_0000;
      3: return 64'hFFFF_FFFF_0000_0000;
      default: return 64'hDEAD_BEEF_FFFF_FFFF;
    endcase
  endfunction

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk(!res_valid && !fault_valid && res_ax == 0, "R10 reset outputs", {res_valid, fault_valid}, 0);
        rst_n = 1'b1;
        run_one(4'h0, 1, 1, 64'h0, 1, 24'h0F01D0, 1);
        chk(res_ax == 64'h1 && res_dx == 64'h0, "R10 reset value", res_ax, 1);
        preload(32'h0000_0001, 64'hFFFF_FFFF_FFFF_FFFF);
        run_one(4'h0, 1, 1, 64'h0, 1, 24'h0F01D0, 0);
        chk(res_ax == 64'h1, "R10 nonzero preload ignored", res_ax, 1);
        preload(32'h0, 64'hCAFE_F00D_1357_9BDF);
        run_one(4'h0, 1, 1, 64'h0, 0, 24'h0F01D0, 0);
        chk(res_ax[31:0] == 32'h1357_9BDF, "R10 preload idx0", res_ax, 64'h1357_9BDF);
        run_one(4'h0, 1, 1, 64'h0, 1, 24'h0F01D1, 1);
        run_one(4'h0, 1, 1, 64'h0, 1, 24'h0F00D0, 1);
        run_one(4'h8, 0, 0, 64'h5, 0, 24'h0E01D0, 0);
        for (int p = 0; p < 16; p++)
          for (int f = 0; f < 4; f++)
            for (int k = 0; k < 5; k++)
              for (int m = 0; m < 2; m++)
                run_one(p[3:0], f[1], f[0], idx_pick(k), m[0], 24'h0F01D0, (k == 0));
        preload(32'h0, 64'h8000_0001_7FFF_FFFE);
        for (int m = 0; m < 2; m++) run_one(4'h0, 1, 1, 64'h1234_5678_0000_0000, m[0], 24'h0F01D0, 1);
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule